// File: doc/BRIEF.md
# Four-Mode Trigger Interrupt Controller

This block collects up to 32 interrupt request lines into one interrupt output. Each line is brought into the clock domain through a two-flop synchroniser. A per-line polarity bit and a per-line kind bit then choose one of four trigger modes: rising edge, falling edge, high level or low level. A latch register holds the qualified events. An enable register picks which events may reach the output. The pending-and-enabled view is readable, and the single output is the OR of that view.

Software reaches the block through a plain single-cycle register port: address, write strobe, write data and combinational read data. Edge events are acknowledged by writing ones to the latch register. Level events follow the line and clear when the line drops back. Several controllers can be chained by wiring the output of one into a request line of another. The port has no data stream, so it carries no valid/ready handshake. Every write takes effect at the clock edge where the strobe is high, and a read returns data in the same cycle as its address.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset the enable (0x00), polarity (0x0C), kind (0x10) and fast-select (0x14) registers read zero and `irq_o` is low.
- R2: The enable register at offset 0x00 reads back the last value written to it. A bit value of 1 enables its line.
- R3: A line whose kind bit (offset 0x10) is 0 is level-triggered. Its latch bit (offset 0x04) equals the line when its polarity bit (offset 0x0C) is 1, and equals the inverted line when the polarity bit is 0. The latch bit reflects a change on the line on the third rising clock edge after that change.
- R4: A line with kind bit 1 and polarity bit 1 sets its latch bit on a rising edge of the synchronised line. The bit stays set after the line returns low.
- R5: A line with kind bit 1 and polarity bit 0 sets its latch bit on a falling edge of the synchronised line, and holds it.
- R6: Writing to offset 0x04 clears every edge-mode latch bit whose write-data bit is 1, and leaves the bits whose write-data bit is 0 unchanged.
- R7: The status register at offset 0x08 reads as latch AND enable. Writes to it have no effect.
- R8: `irq_o` is high exactly when the status register is nonzero.
- R9: The fast-select register at offset 0x14 reads back the last value written, and its contents have no effect on `irq_o`.
- R10: A read from any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 returns zero.
- R11: The `irq_o` of one controller, wired to a level-high enabled line of a second controller, drives the second controller's `irq_o` three clock edges later.
- R12: When an edge event and a clear of the same bit arrive in the same cycle, the bit is left set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (32) | Asynchronous interrupt request lines |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq_o | output | 1 | OR of all pending, enabled lines |

## Verification
The level path is tried with mixed polarity masks against several line patterns. This shows whether each polarity bit inverts only its own line and whether the latch follows both an assertion and a release. The edge path drives a byte of lines high and then low, with half of the byte set for rising edges and half for falling edges. Each step therefore sets only one half, and this shows up a swapped edge sense or a latch that fails to hold. Acknowledge patterns that write a mix of ones and zeros, and an all-zero write, show whether a clear touches only its own bits. A second controller fed by the first checks the chained path and its three-edge lag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register file (fixed by the software view)
  localparam int unsigned OFF_ENABLE = 'h00;
  localparam int unsigned OFF_LATCH  = 'h04;
  localparam int unsigned OFF_STATUS = 'h08;
  localparam int unsigned OFF_POLAR  = 'h0C;
  localparam int unsigned OFF_KIND   = 'h10;
  localparam int unsigned OFF_FSEL   = 'h14;

  // Synchroniser depth on each request line
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_LATCH,
    SEL_STATUS,
    SEL_POLAR,
    SEL_KIND,
    SEL_FSEL
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] kind_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] latch_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic rise, fall, lvl;
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    assign lvl  = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign hit[i] = kind_i[i] & (pol_i[i] ? rise : fall);

    always_comb begin
      if (kind_i[i]) latch_d[i] = (latch_q[i] & ~ack_i[i]) | hit[i];
      else           latch_d[i] = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign latch_o = latch_q;

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(latch_q) & ~$past(ack_i) & $past(kind_i)) & ~latch_q) == '0); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_i) & $past(kind_i) & ~$past(hit)) & latch_q) == '0); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) & ~latch_q) == '0); // R12
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   latch_i,
  output logic [NSRC-1:0]   enable_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   kind_o,
  output logic [NSRC-1:0]   ack_o,
  output logic [NSRC-1:0]   status_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(OFF_LATCH);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_POLAR  = ADDR_W'(OFF_POLAR);
  localparam logic [ADDR_W-1:0] A_KIND   = ADDR_W'(OFF_KIND);
  localparam logic [ADDR_W-1:0] A_FSEL   = ADDR_W'(OFF_FSEL);

  reg_sel_e        sel;
  logic [NSRC-1:0] wbits;
  logic [NSRC-1:0] enable_q, pol_q, kind_q, fsel_q;
  logic [NSRC-1:0] rsel;
  logic            known;

  assign wbits = wdata_i[NSRC-1:0];

  always_comb begin
    case (addr_i)
      A_ENABLE: sel = SEL_ENABLE;
      A_LATCH:  sel = SEL_LATCH;
      A_STATUS: sel = SEL_STATUS;
      A_POLAR:  sel = SEL_POLAR;
      A_KIND:   sel = SEL_KIND;
      A_FSEL:   sel = SEL_FSEL;
      default:  sel = SEL_NONE;
    endcase
  end

  assign known = (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      pol_q    <= '0;
      kind_q   <= '0;
      fsel_q   <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_ENABLE: enable_q <= wbits;
        SEL_POLAR:  pol_q    <= wbits;
        SEL_KIND:   kind_q   <= wbits;
        SEL_FSEL:   fsel_q   <= wbits;
        default:    ;
      endcase
    end
  end

  assign ack_o    = (we_i && sel == SEL_LATCH) ? wbits : '0;
  assign status_o = latch_i & enable_q;

  always_comb begin
    case (sel)
      SEL_ENABLE: rsel = enable_q;
      SEL_LATCH:  rsel = latch_i;
      SEL_STATUS: rsel = status_o;
      SEL_POLAR:  rsel = pol_q;
      SEL_KIND:   rsel = kind_q;
      SEL_FSEL:   rsel = fsel_q;
      default:    rsel = '0;
    endcase
  end

  assign rdata_o  = DATA_W'(rsel);
  assign enable_o = enable_q;
  assign pol_o    = pol_q;
  assign kind_o   = kind_q;

  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (rdata_o == '0)); // R10
  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_i) && $past(addr_i) == A_STATUS) |-> $stable(enable_q)); // R7
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0] sync_w, latch_w, enable_w, pol_w, kind_w, ack_w, status_w;

  irqc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (sync_w)
  );

  irqc_trigger #(.WIDTH(NSRC)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_w),
    .pol_i   (pol_w),
    .kind_i  (kind_w),
    .ack_i   (ack_w),
    .latch_o (latch_w)
  );

  irqc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr),
    .we_i     (bus_we),
    .wdata_i  (bus_wdata),
    .latch_i  (latch_w),
    .enable_o (enable_w),
    .pol_o    (pol_w),
    .kind_o   (kind_w),
    .ack_o    (ack_w),
    .status_o (status_w),
    .rdata_o  (bus_rdata)
  );

  assign irq_o = |status_w;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (enable_w != '0)); // R8
  AST_STATUS_WITHIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w & ~latch_w) == '0); // R7
endmodule

// File: tb/irq_trigger_ctrl_bench.sv
`timescale 1ns/1ps
module irq_trigger_ctrl_bench;
  localparam int unsigned NSRC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  logic [7:0]  t_addr = '0;
  logic        t_we = 1'b0;
  logic [31:0] t_wdata = '0;
  logic [31:0] t_rdata;
  logic        t_irq;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_trigger_ctrl u_irq_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  irq_trigger_ctrl u_tail (
    .clk(clk), .rst_n(rst_n), .src_i({31'b0, irq}), .bus_addr(t_addr),
    .bus_we(t_we), .bus_wdata(t_wdata), .bus_rdata(t_rdata), .irq_o(t_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic twr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    t_addr = a; t_wdata = d; t_we = 1'b1;
    @(negedge clk);
    t_we = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] lvl_exp(input logic [31:0] s, input logic [31:0] p);
    return (s & p) | (~s & ~p);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 enable", v, 32'h0);
    rd(8'h0C, v); check("R1 polarity", v, 32'h0);
    rd(8'h10, v); check("R1 kind", v, 32'h0);
    rd(8'h14, v); check("R1 fsel", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h04, v); check("R3 low-level after reset", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0003); rd(8'h00, v); check("R2 enable rw", v, 32'hA5A5_0003);
    wr(8'h00, 32'h0);         rd(8'h00, v); check("R2 enable clear", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    logic [31:0] p = 32'hFFFF_0000;
    wr(8'h0C, p);
    drive_src(32'h00F0_00F0); rd(8'h04, v); check("R3 level mix", v, lvl_exp(32'h00F0_00F0, p));
    drive_src(32'hFFFF_0000); rd(8'h04, v); check("R3 level all", v, lvl_exp(32'hFFFF_0000, p));
    wr(8'h0C, 32'hFFFF_FFFF);
    drive_src(32'h0);         rd(8'h04, v); check("R3 level release", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(8'h0C, 32'h0000_000F);
    drive_src(32'h0);
    wr(8'h10, 32'h0000_00FF);
    wr(8'h04, 32'h0000_00FF);
    rd(8'h04, v); check("R6 edge bits cleared", v & 32'hFF, 32'h0);
    drive_src(32'h0000_00FF);
    rd(8'h04, v); check("R4 rising latched", v & 32'hFF, 32'h0F);
    drive_src(32'h0);
    rd(8'h04, v); check("R5 falling latched", v & 32'hFF, 32'hFF);
    repeat (4) @(negedge clk);
    rd(8'h04, v); check("R4 held after release", v & 32'hFF, 32'hFF);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(8'h04, 32'h0000_0005); rd(8'h04, v); check("R6 selective clear", v & 32'hFF, 32'hFA);
    wr(8'h04, 32'h0);         rd(8'h04, v); check("R6 zero write", v & 32'hFF, 32'hFA);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0022);
    rd(8'h08, v); check("R7 status", v, 32'h22);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08, v); check("R7 status write inert", v, 32'h22);
    wr(8'h00, 32'h0);
    rd(8'h08, v); check("R7 status masked", v, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fsel();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); check("R9 fsel rw", v, 32'hFFFF_FFFF);
    check("R9 irq unaffected", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0000_0002);
    wr(8'h14, 32'h0);
    @(negedge clk); check("R9 irq with fsel clear", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    rd(8'h18, v); check("R10 0x18", v, 32'h0);
    rd(8'h1C, v); check("R10 0x1C", v, 32'h0);
    rd(8'h40, v); check("R10 0x40", v, 32'h0);
    rd(8'h03, v); check("R10 0x03", v, 32'h0);
  endtask

  task automatic t_cascade();
    twr(8'h0C, 32'h1);
    twr(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    check("R11 tail idle", {31'b0, t_irq}, 32'h0);
    @(negedge clk);
    addr = 8'h00; wdata = 32'h2; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    check("R11 head raised", {31'b0, irq}, 32'h1);
    repeat (2) @(posedge clk);
    @(negedge clk); check("R11 tail before lag", {31'b0, t_irq}, 32'h0);
    @(posedge clk);
    @(negedge clk); check("R11 tail after lag", {31'b0, t_irq}, 32'h1);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'h0000_0100);
    wr(8'h10, 32'h0000_0100);
    drive_src(32'h0);
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, v); check("R12 bit 8 cleared first", v & 32'h100, 32'h0);
    // line rises; the edge reaches the latch on the third posedge, the clear is timed for it
    @(negedge clk);
    src = 32'h0000_0100;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    addr = 8'h04; wdata = 32'h0000_0100; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    rd(8'h04, v); check("R12 set beats clear", v & 32'h100, 32'h100);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_level();
    t_edge();
    t_ack();
    t_status();
    t_fsel();
    t_undef();
    t_cascade();
    t_race();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule